// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits beside a DRAM controller's ECC checker and records what that checker reports. The checker raises a one-cycle pulse for a correctable error or an uncorrectable error. With the pulse it presents the physical address, an 8-bit syndrome and the channel (0 or 1) that held the data. The block keeps one sticky flag for each error class. It also keeps a single set of captured fields: the 4 KiB block address, the syndrome and the channel.

Software polls the block through a plain register port with a 2-bit register select, a write strobe, write data and a combinational read bus. A correctable error that is already logged can be replaced by an uncorrectable one. An uncorrectable error that is already logged is never disturbed by a correctable one. The flags are cleared by writing ones to them. Software that sees the flags change between two reads takes the fields from the second read as the valid ones.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero.
- R2: The register select picks the register: 0 is error status, 1 is error address, 2 is syndrome, 3 is channel.
- R3: A correctable pulse with both flags clear sets status bit 0 on the next clock edge. On the same edge it loads the block address, the syndrome and the channel.
- R4: An uncorrectable pulse sets status bit 7. If bit 7 was clear, it also loads all captured fields, replacing those of a logged correctable error, and bit 0 stays as it was.
- R5: While bit 7 is set, a correctable pulse neither sets bit 0 nor changes any captured field.
- R6: While an error of a class is logged, a later error of the same class leaves the captured fields unchanged, so the first error wins.
- R7: A write to register 0 clears status bit 0 and bit 7 where the write data holds a 1 and leaves them where it holds a 0. Writing 0x0081 clears both.
- R8: If a pulse sets a status bit in the same cycle as a write of 1 to that bit, the bit ends up set.
- R9: The address register returns the stored block address in bits 31:12 and zero in bits 11:0. The channel register returns zero above bit 0, and the status register returns zero outside bits 0 and 7.
- R10: Writes to registers 1, 2 and 3 have no effect, and neither do write-data bits other than 0 and 7 in a status write.
- R11: Once both flags are clear, the next error of either class loads all captured fields.
- R12: A correctable and an uncorrectable pulse in the same cycle with nothing logged set only bit 7 and capture the presented data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_pulse | input | 1 | Correctable error report, one cycle |
| ue_pulse | input | 1 | Uncorrectable error report, one cycle |
| err_addr | input | 32 | Physical address of the failing access |
| err_syn | input | 8 | ECC syndrome of the failing access |
| err_chan | input | 1 | Channel of the failing access |
| reg_sel | input | 2 | Register select (0 status, 1 address, 2 syndrome, 3 channel) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register, combinational |

## Verification
The capture logic is driven with a sequence of cases:
- A lone correctable error, followed by a second correctable error carrying different data. This tells first-wins capture apart from last-wins capture.
- An uncorrectable error on top of a logged correctable error. This shows whether the overwrite happens and whether bit 0 survives it.
- Correctable and uncorrectable errors arriving while an uncorrectable error is held. These separate a blocked correctable error from an accidental reload.

Clears are tried with single-bit masks, the combined mask and masks that contain only the other bits. Set and clear are also made to collide in one cycle. Writes to the read-only registers are checked at the read port. A reload after a full clear, and simultaneous pulses of both classes, are checked as well.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_SYN    = 2'd2,
    SEL_CHAN   = 2'd3
  } reg_sel_e;

  localparam int CE_BIT = 0;
  localparam int UE_BIT = 7;
  localparam int STATUS_W = 16;

  // sticky flag update: a set event beats a clear request
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [STATUS_W-1:0] status_word(input logic ce, input logic ue);
    logic [STATUS_W-1:0] w;
    w = '0;
    w[CE_BIT] = ce;
    w[UE_BIT] = ue;
    return w;
  endfunction
endpackage

// File: rtl/ecc_log_event.sv
module ecc_log_event (
  input  logic ce_pulse,
  input  logic ue_pulse,
  input  logic ce_flag,
  input  logic ue_flag,
  output logic set_ce,
  output logic set_ue,
  output logic load_ev
);
  logic ue_takes;
  logic ce_takes;

  always_comb begin
    set_ue   = ue_pulse;
    // a correctable report is dropped while an uncorrectable one is held or arriving
    set_ce   = ce_pulse & ~ue_pulse & ~ue_flag;
    ue_takes = ue_pulse & ~ue_flag;
    ce_takes = set_ce & ~ce_flag;
    load_ev  = ue_takes | ce_takes;
  end
endmodule

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_ce,
  input  logic set_ue,
  input  logic clr_ce,
  input  logic clr_ue,
  output logic ce_flag,
  output logic ue_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_flag <= 1'b0;
      ue_flag <= 1'b0;
    end else begin
      ce_flag <= flag_next(ce_flag, set_ce, clr_ce);
      ue_flag <= flag_next(ue_flag, set_ue, clr_ue);
    end
  end

  assert_ue_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_ue |=> ue_flag);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ce && clr_ce) |=> ce_flag);
  assert_clear_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && !set_ce) |=> !ce_flag);
  assert_clear_ue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ue && !set_ue) |=> !ue_flag);
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int ADDR_W   = 32,
  parameter int GRAIN_SH = 12,
  parameter int SYN_W    = 8,
  localparam int BLK_W   = ADDR_W - GRAIN_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  output logic [BLK_W-1:0]  blk_q,
  output logic [SYN_W-1:0]  syn_q,
  output logic              chan_q
);
  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GRAIN_SH];
  endfunction

  logic unused_low_addr;
  assign unused_low_addr = ^err_addr[GRAIN_SH-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (load_ev) begin
      blk_q  <= block_of(err_addr);
      syn_q  <= err_syn;
      chan_q <= err_chan;
    end
  end

  assert_load_syn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (syn_q == $past(err_syn)) && (chan_q == $past(err_chan)));
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
  import ecc_log_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GRAIN_SH = 12,
  parameter int SYN_W    = 8,
  localparam int BLK_W   = DATA_W - GRAIN_SH
) (
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ce_flag,
  input  logic              ue_flag,
  input  logic [BLK_W-1:0]  blk_q,
  input  logic [SYN_W-1:0]  syn_q,
  input  logic              chan_q,
  output logic              clr_ce,
  output logic              clr_ue,
  output logic [DATA_W-1:0] reg_rdata
);
  logic wr_status;
  logic unused_wdata;

  assign wr_status    = reg_wr && (reg_sel_e'(reg_sel) == SEL_STATUS);
  assign clr_ce       = wr_status & reg_wdata[CE_BIT];
  assign clr_ue       = wr_status & reg_wdata[UE_BIT];
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_STATUS: reg_rdata = DATA_W'(status_word(ce_flag, ue_flag));
      SEL_ADDR:   reg_rdata = {blk_q, {GRAIN_SH{1'b0}}};
      SEL_SYN:    reg_rdata = DATA_W'(syn_q);
      default:    reg_rdata = DATA_W'(chan_q);
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W   = 32,
  parameter int GRAIN_SH = 12,
  parameter int SYN_W    = 8,
  localparam int BLK_W   = ADDR_W - GRAIN_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_pulse,
  input  logic              ue_pulse,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              err_chan,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata
);
  logic set_ce, set_ue, load_ev;
  logic clr_ce, clr_ue;
  logic ce_flag, ue_flag;
  logic [BLK_W-1:0] blk_q;
  logic [SYN_W-1:0] syn_q;
  logic chan_q;

  ecc_log_event u_event (
    .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
    .ce_flag(ce_flag), .ue_flag(ue_flag),
    .set_ce(set_ce), .set_ue(set_ue), .load_ev(load_ev)
  );

  ecc_log_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_ce(set_ce), .set_ue(set_ue),
    .clr_ce(clr_ce), .clr_ue(clr_ue),
    .ce_flag(ce_flag), .ue_flag(ue_flag)
  );

  ecc_log_capture #(.ADDR_W(ADDR_W), .GRAIN_SH(GRAIN_SH), .SYN_W(SYN_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev),
    .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
    .blk_q(blk_q), .syn_q(syn_q), .chan_q(chan_q)
  );

  ecc_log_regif #(.DATA_W(ADDR_W), .GRAIN_SH(GRAIN_SH), .SYN_W(SYN_W)) u_regif (
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ce_flag(ce_flag), .ue_flag(ue_flag),
    .blk_q(blk_q), .syn_q(syn_q), .chan_q(chan_q),
    .clr_ce(clr_ce), .clr_ue(clr_ue), .reg_rdata(reg_rdata)
  );

  // a held uncorrectable error blocks correctable reports
  assert_ce_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_flag && ce_pulse && !ce_flag) |=> !ce_flag);
  // held fields stay put unless a fresh uncorrectable error takes over
  assert_first_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_flag || ue_flag) && !(ue_pulse && !ue_flag)) |=>
      ($stable(syn_q) && $stable(blk_q) && $stable(chan_q)));
  assert_ue_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse && !ue_flag) |=> (blk_q == $past(err_addr[ADDR_W-1:GRAIN_SH])));
  assert_both_pulses_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pulse && ue_pulse && !ce_flag && !clr_ce) |=> (ue_flag && !ce_flag));
endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_pulse = 1'b0;
  logic        ue_pulse = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic        err_chan = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
    .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  // status, address, syndrome, channel as software would see them
  task automatic expect_regs(input string req, input logic [31:0] st, input logic [31:0] ad,
                             input logic [7:0] sy, input logic ch);
    logic [31:0] v;
    rd(2'd0, v); chk(req, "status", v, st);
    rd(2'd1, v); chk(req, "address", v, ad);
    rd(2'd2, v); chk(req, "syndrome", v, {24'h0, sy});
    rd(2'd3, v); chk(req, "channel", v, {31'h0, ch});
  endtask

  // one-cycle error report, optionally with a status write in the same cycle
  task automatic report(input logic ce, input logic ue, input logic [31:0] a,
                        input logic [7:0] s, input logic c,
                        input logic do_wr, input logic [31:0] wv);
    @(negedge clk);
    ce_pulse = ce; ue_pulse = ue; err_addr = a; err_syn = s; err_chan = c;
    reg_wr = do_wr; reg_sel = 2'd0; reg_wdata = wv;
    @(negedge clk);
    ce_pulse = 1'b0; ue_pulse = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    expect_regs("R1", 32'h0, 32'h0, 8'h00, 1'b0);
  endtask

  task automatic t_first_ce;
    report(1, 0, 32'h1234_5ABC, 8'h3C, 1'b1, 0, 0);
    // R2 R3 R9: map, capture, low address bits zero
    expect_regs("R3", 32'h1, 32'h1234_5000, 8'h3C, 1'b1);
  endtask

  task automatic t_ce_repeat;
    report(1, 0, 32'h0BAD_0FFF, 8'h11, 1'b0, 0, 0);
    expect_regs("R6", 32'h1, 32'h1234_5000, 8'h3C, 1'b1);
  endtask

  task automatic t_ue_over_ce;
    report(0, 1, 32'hFEDC_B123, 8'hA5, 1'b0, 0, 0);
    expect_regs("R4", 32'h81, 32'hFEDC_B000, 8'hA5, 1'b0);
  endtask

  task automatic t_ce_under_ue;
    logic [31:0] v;
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, v); chk("R7", "clear bit0 only", v, 32'h80);
    report(1, 0, 32'h5555_5555, 8'h77, 1'b1, 0, 0);
    expect_regs("R5", 32'h80, 32'hFEDC_B000, 8'hA5, 1'b0);
  endtask

  task automatic t_ue_repeat;
    report(0, 1, 32'h0000_3000, 8'h42, 1'b1, 0, 0);
    expect_regs("R6", 32'h80, 32'hFEDC_B000, 8'hA5, 1'b0);
  endtask

  task automatic t_ignored_writes;
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FF7E);
    expect_regs("R10", 32'h80, 32'hFEDC_B000, 8'hA5, 1'b0);
  endtask

  task automatic t_clear_and_reload;
    logic [31:0] v;
    report(1, 0, 32'h0, 8'h0, 1'b0, 0, 0);  // blocked by held bit 7
    wr(2'd0, 32'h0000_0081);
    rd(2'd0, v); chk("R7", "clear both", v, 32'h0);
    report(1, 0, 32'h8000_1FFF, 8'hC3, 1'b1, 0, 0);
    expect_regs("R11", 32'h1, 32'h8000_1000, 8'hC3, 1'b1);
  endtask

  task automatic t_set_beats_clear;
    logic [31:0] v;
    report(1, 0, 32'h2222_2000, 8'h01, 1'b0, 1, 32'h0000_0001);
    rd(2'd0, v); chk("R8", "bit0 set wins", v, 32'h1);
    rd(2'd2, v); chk("R6", "held CE syndrome", v, 32'hC3);
    report(0, 1, 32'h3333_3000, 8'h99, 1'b0, 1, 32'h0000_0080);
    rd(2'd0, v); chk("R8", "bit7 set wins", v, 32'h81);
    rd(2'd2, v); chk("R4", "UE syndrome", v, 32'h99);
    wr(2'd0, 32'h0000_0081);
    rd(2'd0, v); chk("R7", "clear after collide", v, 32'h0);
  endtask

  task automatic t_both_classes;
    report(1, 1, 32'h4444_4ABC, 8'h5A, 1'b1, 0, 0);
    expect_regs("R12", 32'h80, 32'h4444_4000, 8'h5A, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_ce;
    t_ce_repeat;
    t_ue_over_ce;
    t_ce_under_ue;
    t_ue_repeat;
    t_ignored_writes;
    t_clear_and_reload;
    t_set_beats_clear;
    t_both_classes;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule